// File: doc/BRIEF.md
# Masked PCI Configuration Register File

This block keeps the 256-byte configuration image of a single PCI function and serves it through a plain request port. Each request gives a byte offset and a length of 1, 2 or 4 bytes, plus a write strobe with write data and/or a read strobe. A write places its lowest data byte at the offset and each following byte one address higher. It never wraps past the last byte. Each byte is merged under its own write-enable mask, so identity, type and reserved bits keep their fixed values no matter what software writes.

The masks are computed at elaboration from parameters: the identity values, the size and kind of each base address register, and the size of the expansion ROM window. Reads are registered. They return the addressed bytes assembled little-endian one cycle after the strobe. A read that breaks the length/offset rule returns all ones. After any write that may move the function's address decode, the block raises a one-cycle remap pulse. The pulse is meant to tell the surrounding decode logic to re-evaluate its windows.

Top module: `cfg_space_top`

## Requirements
- R1: The space has 256 bytes. A write of length 1, 2 or 4 puts data byte k at offset+k, for ascending k. Bytes that would land beyond 0xFF are dropped and do not wrap to 0x00. Without a write strobe, no byte changes.
- R2: Every written byte takes the value (old AND NOT mask) OR (data AND mask), using that byte's own write-enable mask.
- R3: In the command byte at 0x04, only bits 0 (I/O enable), 1 (memory enable) and 2 (bus master) are writable. Byte 0x05 is read-only zero.
- R4: Bytes 0x0C and 0x3C, and every byte from 0x40 to 0xFF, are fully writable. The following are read-only and hold their parameter values:
  - vendor ID at 0x00–0x01
  - device ID at 0x02–0x03
  - revision at 0x08
  - class code at 0x09–0x0B
  - header type at 0x0E
- R5: Base address register n (n = 0..5) is a 32-bit little-endian word at 0x10+4n. Its write mask is NOT(size−1), and a size of 0 makes it fully read-only zero. An I/O register reads bit 0 as 1, and a memory register reads bit 0 as 0.
- R6: The expansion ROM word at 0x30 has write mask NOT(size−1) with bit 0 (enable) also writable.
- R7: A read strobe produces rd_valid in the next cycle, with rd_data assembled little-endian from the offset. A 2-byte read is zero-extended and a 1-byte read is zero-extended.
- R8: A read returns 0xFFFFFFFF in any of these cases:
  - length 4 with offset above 0xFC
  - length 2 with offset above 0xFE
  - any length other than 1, 2 or 4
- R9: remap is high for exactly the cycle after a write when that write changed any byte in 0x10–0x27, or flipped command bit 0 or bit 1. A write that changes nothing in that area (including bus-master-only changes and rewrites of equal values) gives no pulse.
- R10: After synchronous reset, every writable bit is zero, read-only fields hold their parameter values, rd_valid is 0 and remap is 0.
- R11: A read and a write in the same cycle are both performed. The read returns the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_off | input | 8 | Byte offset of the request |
| req_len | input | 3 | Length in bytes (1, 2 or 4) |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data, low byte goes to req_off |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | rd_data is valid this cycle |
| remap | output | 1 | One-cycle pulse: decode-relevant state changed |

## Verification
Two functions can coincide in one cycle: a read and a write hitting the same word, and a write that both updates a base address register and produces a remap pulse while a read of that register is in flight. The bench provokes both by raising rd_en and wr_en together on the same offset. It expects the read to return the value from before the write, the remap pulse to appear in the cycle the read data is returned, and a following read to show the merged new value.

// File: rtl/cfg_space_pkg.sv
package cfg_space_pkg;

    localparam int unsigned CFG_BYTES  = 256;
    localparam int unsigned NUM_BARS   = 6;
    localparam int unsigned DATA_BYTES = 4;

    localparam int unsigned OFS_CMD      = 'h04;
    localparam int unsigned OFS_CACHE    = 'h0C;
    localparam int unsigned OFS_BAR_LO   = 'h10;
    localparam int unsigned OFS_BAR_HI   = OFS_BAR_LO + 4 * NUM_BARS;
    localparam int unsigned OFS_ROM      = 'h30;
    localparam int unsigned OFS_INTLINE  = 'h3C;
    localparam int unsigned OFS_DEV_AREA = 'h40;

    localparam logic [7:0] CMD_WMASK  = 8'h07;
    localparam logic [7:0] CMD_DECODE = 8'h03;

    typedef logic [7:0] cfg_byte_t;
    typedef cfg_byte_t [CFG_BYTES-1:0] cfg_image_t;

    typedef struct packed {
        logic [15:0] vendor;
        logic [15:0] device;
        logic [7:0]  rev;
        logic [23:0] class_code;
        logic [7:0]  hdr;
    } cfg_ident_t;

    typedef struct packed {
        logic [7:0]  off;
        logic [2:0]  len;
        logic        wr;
        logic [31:0] wdata;
        logic        rd;
    } cfg_req_t;

    function automatic logic [31:0] size_wmask(logic [31:0] size);
        return (size == 32'd0) ? 32'd0 : ~(size - 32'd1);
    endfunction

    function automatic cfg_byte_t word_byte(logic [31:0] w, int unsigned b);
        return w[8*b +: 8];
    endfunction

    function automatic logic [2:0] lane_count(logic [2:0] len);
        return (len > 3'd4) ? 3'd4 : len;
    endfunction

endpackage

// File: rtl/cfg_mask_rom.sv
module cfg_mask_rom
    import cfg_space_pkg::*;
#(
    parameter cfg_ident_t               IDENT     = '0,
    parameter logic [NUM_BARS*32-1:0]   BAR_SIZES = '0,
    parameter logic [NUM_BARS-1:0]      BAR_IS_IO = '0,
    parameter logic [31:0]              ROM_SIZE  = '0
) (
    output cfg_image_t wmask_o,
    output cfg_image_t init_o
);

    function automatic logic [15:0] byte_entry(int unsigned a);
        cfg_byte_t   m;
        cfg_byte_t   v;
        int unsigned n;
        int unsigned b;
        logic [31:0] rm;
        m = '0;
        v = '0;
        if (a == OFS_CMD) m = CMD_WMASK;
        if (a == OFS_CACHE || a == OFS_INTLINE || a >= OFS_DEV_AREA) m = 8'hFF;
        if (a >= OFS_BAR_LO && a < OFS_BAR_HI) begin
            n = (a - OFS_BAR_LO) / 4;
            b = (a - OFS_BAR_LO) % 4;
            m = word_byte(size_wmask(BAR_SIZES[32*n +: 32]), b);
            if (b == 0 && BAR_IS_IO[n] && BAR_SIZES[32*n +: 32] != 32'd0) v = 8'h01;
        end
        if (a >= OFS_ROM && a < OFS_ROM + 4) begin
            rm = (ROM_SIZE == 32'd0) ? 32'd0 : (size_wmask(ROM_SIZE) | 32'd1);
            m  = word_byte(rm, a - OFS_ROM);
        end
        case (a)
            'h00: v = IDENT.vendor[7:0];
            'h01: v = IDENT.vendor[15:8];
            'h02: v = IDENT.device[7:0];
            'h03: v = IDENT.device[15:8];
            'h08: v = IDENT.rev;
            'h09: v = IDENT.class_code[7:0];
            'h0A: v = IDENT.class_code[15:8];
            'h0B: v = IDENT.class_code[23:16];
            'h0E: v = IDENT.hdr;
            default: ;
        endcase
        return {m, v};
    endfunction

    for (genvar g = 0; g < CFG_BYTES; g++) begin : g_byte
        localparam logic [15:0] ENTRY = byte_entry(g);
        assign wmask_o[g] = ENTRY[15:8];
        assign init_o[g]  = ENTRY[7:0];
    end

endmodule

// File: rtl/cfg_write_merge.sv
module cfg_write_merge
    import cfg_space_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  cfg_image_t cur_i,
    input  cfg_image_t wmask_i,
    input  cfg_req_t   req_i,
    output cfg_image_t next_o,
    output logic       remap_o
);

    localparam int unsigned REMAP_SPAN = OFS_BAR_HI - OFS_BAR_LO;

    logic [2:0]            cnt;
    logic [REMAP_SPAN-1:0] bar_diff;

    assign cnt = lane_count(req_i.len);

    for (genvar g = 0; g < CFG_BYTES; g++) begin : g_lane
        logic [7:0]  rel;
        logic        hit;
        logic [31:0] shifted;
        cfg_byte_t   lane;
        assign rel     = 8'(g) - req_i.off;
        assign hit     = req_i.wr && (8'(g) >= req_i.off) && (rel < 8'(cnt));
        assign shifted = req_i.wdata >> {rel[1:0], 3'b000};
        assign lane    = shifted[7:0];
        assign next_o[g] = hit ? ((cur_i[g] & ~wmask_i[g]) | (lane & wmask_i[g]))
                               : cur_i[g];
    end

    for (genvar k = 0; k < REMAP_SPAN; k++) begin : g_bar_diff
        assign bar_diff[k] = |(cur_i[OFS_BAR_LO + k] ^ next_o[OFS_BAR_LO + k]);
    end

    assign remap_o = (|bar_diff) || (|((cur_i[OFS_CMD] ^ next_o[OFS_CMD]) & CMD_DECODE));

    // R2: bits outside the mask never change across a merge
    p_ro_bits_kept_r2: assert property (@(posedge clk) disable iff (rst)
        ((next_o ^ cur_i) & ~wmask_i) == '0);

endmodule

// File: rtl/cfg_read_fmt.sv
module cfg_read_fmt
    import cfg_space_pkg::*;
(
    input  cfg_image_t  image_i,
    input  logic [7:0]  off_i,
    input  logic [2:0]  len_i,
    output logic [31:0] data_o
);

    logic      ok;
    cfg_byte_t b0, b1, b2, b3;

    always_comb begin
        ok = (len_i == 3'd1)
          || (len_i == 3'd2 && off_i <= 8'hFE)
          || (len_i == 3'd4 && off_i <= 8'hFC);
        b0 = image_i[off_i];
        b1 = image_i[off_i + 8'd1];
        b2 = image_i[off_i + 8'd2];
        b3 = image_i[off_i + 8'd3];
        if (!ok)                 data_o = '1;
        else if (len_i == 3'd1)  data_o = {24'd0, b0};
        else if (len_i == 3'd2)  data_o = {16'd0, b1, b0};
        else                     data_o = {b3, b2, b1, b0};
    end

endmodule

// File: rtl/cfg_space_top.sv
module cfg_space_top
    import cfg_space_pkg::*;
#(
    parameter logic [15:0]            VENDOR_ID  = 16'hABCD,
    parameter logic [15:0]            DEVICE_ID  = 16'h1234,
    parameter logic [7:0]             REVISION   = 8'h05,
    parameter logic [23:0]            CLASS_CODE = 24'h020000,
    parameter logic [7:0]             HEADER     = 8'h00,
    parameter logic [NUM_BARS*32-1:0] BAR_SIZES  = {32'd0, 32'd0, 32'd0, 32'd0, 32'h20, 32'h100},
    parameter logic [NUM_BARS-1:0]    BAR_IS_IO  = 6'b000010,
    parameter logic [31:0]            ROM_SIZE   = 32'h800
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  req_off,
    input  logic [2:0]  req_len,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic        rd_en,
    output logic [31:0] rd_data,
    output logic        rd_valid,
    output logic        remap
);

    localparam cfg_ident_t IDENT = '{vendor: VENDOR_ID, device: DEVICE_ID, rev: REVISION,
                                     class_code: CLASS_CODE, hdr: HEADER};

    cfg_image_t  wmask, init_img, cfg_q, cfg_d;
    cfg_req_t    req;
    logic        remap_d;
    logic [31:0] rd_d;

    assign req = '{off: req_off, len: req_len, wr: wr_en, wdata: wr_data, rd: rd_en};

    cfg_mask_rom #(
        .IDENT(IDENT), .BAR_SIZES(BAR_SIZES), .BAR_IS_IO(BAR_IS_IO), .ROM_SIZE(ROM_SIZE)
    ) u_masks (
        .wmask_o(wmask),
        .init_o (init_img)
    );

    cfg_write_merge u_merge (
        .clk    (clk),
        .rst    (rst),
        .cur_i  (cfg_q),
        .wmask_i(wmask),
        .req_i  (req),
        .next_o (cfg_d),
        .remap_o(remap_d)
    );

    cfg_read_fmt u_rdfmt (
        .image_i(cfg_q),
        .off_i  (req.off),
        .len_i  (req.len),
        .data_o (rd_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= init_img;
            rd_data  <= '0;
            rd_valid <= 1'b0;
            remap    <= 1'b0;
        end else begin
            cfg_q    <= cfg_d;
            rd_valid <= req.rd;
            remap    <= req.wr && remap_d;
            if (req.rd) rd_data <= rd_d;
        end
    end

    // R1: with no write strobe the image holds still
    p_quiet_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(cfg_q));

    // R3: non-writable command bits and byte 0x05 stay zero
    p_cmd_fixed_r3: assert property (@(posedge clk) disable iff (rst)
        cfg_q[OFS_CMD][7:3] == 5'd0 && cfg_q[OFS_CMD+1] == 8'd0);

    // R4: identity bytes keep parameter values
    p_ident_fixed_r4: assert property (@(posedge clk) disable iff (rst)
        {cfg_q[1], cfg_q[0]} == VENDOR_ID && {cfg_q[3], cfg_q[2]} == DEVICE_ID
        && cfg_q[8] == REVISION && cfg_q[14] == HEADER);

    // R7: read data is valid exactly one cycle after a read strobe
    p_rd_follows_r7: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);
    p_rd_cause_r7: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(rd_en));

    // R8: an overlong 4-byte read returns all ones
    p_bad_read_ones_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && req_len == 3'd4 && req_off > 8'hFC) |=> rd_data == 32'hFFFF_FFFF);

    // R9: a remap pulse only follows a write
    p_remap_cause_r9: assert property (@(posedge clk) disable iff (rst)
        remap |-> $past(wr_en));

endmodule

// File: tb/cfg_space_top_tb.sv
`timescale 1ns/1ps
module cfg_space_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  req_off = '0;
    logic [2:0]  req_len = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic        remap;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    cfg_space_top u_dut (
        .clk(clk), .rst(rst), .req_off(req_off), .req_len(req_len),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .rd_valid(rd_valid), .remap(remap)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // one request cycle; results sampled on the following falling edge
    task automatic access(input logic [7:0] off, input logic [2:0] len, input logic wr,
                          input logic [31:0] wd, input logic rd,
                          output logic [31:0] rdat, output logic rmp, output logic rv);
        @(negedge clk);
        req_off = off; req_len = len; wr_en = wr; wr_data = wd; rd_en = rd;
        @(negedge clk);
        rdat = rd_data; rmp = remap; rv = rd_valid;
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic wr(input logic [7:0] off, input logic [2:0] len, input logic [31:0] wd,
                      output logic rmp);
        logic [31:0] d; logic v;
        access(off, len, 1'b1, wd, 1'b0, d, rmp, v);
    endtask

    task automatic rd(input logic [7:0] off, input logic [2:0] len, output logic [31:0] d);
        logic r; logic v;
        access(off, len, 1'b0, '0, 1'b1, d, r, v);
        chk("R7 rd_valid", {31'd0, v}, 32'd1);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R10 rd_valid idle", {31'd0, rd_valid}, 32'd0);
        chk("R10 remap idle", {31'd0, remap}, 32'd0);
        rd(8'h00, 3'd4, d); chk("R10 ids", d, 32'h1234_ABCD);
        rd(8'h08, 3'd4, d); chk("R10 rev/class", d, 32'h0200_0005);
        rd(8'h04, 3'd4, d); chk("R10 cmd zero", d, 32'h0);
        rd(8'h14, 3'd4, d); chk("R5 io bar reset", d, 32'h0000_0001);
        rd(8'h09, 3'd1, d); chk("R7 byte read", d, 32'h0000_0000);
        rd(8'h01, 3'd1, d); chk("R7 byte read ext", d, 32'h0000_00AB);
    endtask

    task automatic t_command;
        logic [31:0] d; logic r;
        wr(8'h04, 3'd2, 32'h0000_FFFF, r); chk("R9 enable toggle pulse", {31'd0, r}, 32'd1);
        rd(8'h04, 3'd2, d);                chk("R3 cmd mask", d, 32'h0000_0007);
        wr(8'h04, 3'd1, 32'h07, r);        chk("R9 same value no pulse", {31'd0, r}, 32'd0);
        wr(8'h04, 3'd1, 32'h03, r);        chk("R9 master only no pulse", {31'd0, r}, 32'd0);
        wr(8'h04, 3'd1, 32'h01, r);        chk("R9 mem off pulse", {31'd0, r}, 32'd1);
        rd(8'h04, 3'd1, d);                chk("R3 cmd value", d, 32'h0000_0001);
    endtask

    task automatic t_ident;
        logic [31:0] d; logic r;
        wr(8'h00, 3'd4, 32'hFFFF_FFFF, r); chk("R9 id write no pulse", {31'd0, r}, 32'd0);
        rd(8'h00, 3'd4, d);                chk("R4 ids read-only", d, 32'h1234_ABCD);
        wr(8'h0C, 3'd4, 32'hFFFF_FFFF, r);
        rd(8'h0C, 3'd4, d);                chk("R4 cache line only", d, 32'h0000_00FF);
        wr(8'h3C, 3'd2, 32'h0000_FFFF, r);
        rd(8'h3C, 3'd2, d);                chk("R4 int line writable", d, 32'h0000_00FF);
    endtask

    task automatic t_bars;
        logic [31:0] d; logic r;
        wr(8'h10, 3'd4, 32'hFFFF_FFFF, r); chk("R9 bar0 pulse", {31'd0, r}, 32'd1);
        rd(8'h10, 3'd4, d);                chk("R5 bar0 mask", d, 32'hFFFF_FF00);
        wr(8'h14, 3'd4, 32'hFFFF_FFFF, r); chk("R9 bar1 pulse", {31'd0, r}, 32'd1);
        rd(8'h14, 3'd4, d);                chk("R5 bar1 io mask", d, 32'hFFFF_FFE1);
        wr(8'h18, 3'd4, 32'hFFFF_FFFF, r); chk("R9 unused bar no pulse", {31'd0, r}, 32'd0);
        rd(8'h18, 3'd4, d);                chk("R5 unused bar", d, 32'h0);
        wr(8'h10, 3'd4, 32'hFFFF_FFFF, r); chk("R9 bar rewrite no pulse", {31'd0, r}, 32'd0);
        wr(8'h30, 3'd4, 32'hFFFF_FFFF, r); chk("R9 rom no pulse", {31'd0, r}, 32'd0);
        rd(8'h30, 3'd4, d);                chk("R6 rom mask", d, 32'hFFFF_F801);
    endtask

    task automatic t_lanes;
        logic [31:0] d; logic r;
        wr(8'h41, 3'd2, 32'h0000_BEEF, r);
        rd(8'h40, 3'd4, d);                chk("R1 byte order", d, 32'h00BE_EF00);
        wr(8'h50, 3'd4, 32'hA5A5_A5A5, r);
        wr(8'h51, 3'd1, 32'hFFFF_FF3C, r);
        rd(8'h50, 3'd4, d);                chk("R2 single byte merge", d, 32'hA5A5_3CA5);
        wr(8'hFE, 3'd4, 32'h4433_2211, r);
        rd(8'hFE, 3'd2, d);                chk("R1 tail write", d, 32'h0000_2211);
        rd(8'hFC, 3'd4, d);                chk("R7 last word", d, 32'h2211_0000);
        rd(8'hFF, 3'd1, d);                chk("R7 last byte", d, 32'h0000_0022);
        rd(8'h00, 3'd2, d);                chk("R1 no wrap", d, 32'h0000_ABCD);
    endtask

    task automatic t_bad_reads;
        logic [31:0] d;
        rd(8'hFD, 3'd4, d); chk("R8 len4 past end", d, 32'hFFFF_FFFF);
        rd(8'hFF, 3'd2, d); chk("R8 len2 past end", d, 32'hFFFF_FFFF);
        rd(8'h00, 3'd3, d); chk("R8 odd length", d, 32'hFFFF_FFFF);
    endtask

    task automatic t_same_cycle;
        logic [31:0] d; logic r; logic v;
        wr(8'h60, 3'd4, 32'h1111_1111, r);
        access(8'h60, 3'd4, 1'b1, 32'h2222_2222, 1'b1, d, r, v);
        chk("R11 read sees old", d, 32'h1111_1111);
        rd(8'h60, 3'd4, d); chk("R11 write landed", d, 32'h2222_2222);
        access(8'h10, 3'd4, 1'b1, 32'h0000_1234, 1'b1, d, r, v);
        chk("R11 bar read old", d, 32'hFFFF_FF00);
        chk("R9 pulse with read", {31'd0, r}, 32'd1);
        rd(8'h10, 3'd4, d); chk("R5 bar aligned", d, 32'h0000_1200);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_command();
        t_ident();
        t_bars();
        t_lanes();
        t_bad_reads();
        t_same_cycle();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule